// File: doc/BRIEF.md
# Device Address Translation Unit

This block turns 32-bit addresses issued by bus-mastering devices into 34-bit physical addresses. The device-visible window it maps always ends at the top of the 32-bit space. Its size is set by a 3-bit size code: code n maps 8 MiB << n, so the lowest mapped address runs from 0xFF800000 (n=0) down to 0xC0000000 (n=7). Each 8 KiB page of the window has one 8-byte entry in a flat table in physical memory. Entry k describes the k-th page above the window base.

Software programs three registers through a write-only register port: a control word, the table base and a flush address. A device presents one request at a time on a valid/ready port, as an address plus a read/write flag. The unit either answers at once (translation off, address outside the window, or a hit in its one-entry cache) or fetches the entry through a memory read port. It then answers with a physical address and four attribute bits, or with a fault code. Registers are written only while no request is in flight.

The one-entry cache keeps the last valid entry it fetched, tagged with its page. A flush write naming an address in that page drops it. Any write to the control or table-base register also drops it.

Top module: `dvma_xlate`

## Requirements
- R1: After reset `req_ready` is 1, `rsp_valid` and `mem_req_valid` are 0, and translation is off, so the first request is passed through.
- R2: When control bit 0 (enable) is 0, a read or write request answers with `rsp_paddr` = request address zero-extended to 34 bits, `rsp_fault` = 0 and `rsp_attr` = 0, with no memory fetch; this also holds while the cache holds an entry.
- R3: Control bits 18:16 give size code n; the window base is 2^32 − (8 MiB << n). A request below the base answers `rsp_fault` = 1 (out of range), with paddr and attr 0 and no fetch. Control bits 1 and 2 are stored with no effect on translation.
- R4: A miss inside the window fetches one entry from address T + (((addr − base) >> 13) << 3), where T is the table base written at register offset 0x08 with bits 12:0 forced to zero.
- R5: For a usable entry `rsp_paddr` = {entry[33:13], addr[12:0]} and `rsp_attr` = {entry[60] streamable, entry[59] local segment, entry[4] cacheable, entry[1] writable}, with `rsp_fault` = 0.
- R6: An entry with bit 63 clear answers `rsp_fault` = 2 (invalid), with paddr and attr 0, and is not cached.
- R7: A write request to a valid entry with bit 1 clear answers `rsp_fault` = 3 (protection), with paddr and attr 0; a read of the same entry succeeds. The entry is cached either way.
- R8: A request to the page held in the cache answers from the cache with no fetch, even if the table in memory has changed.
- R9: A write to register offset 0x10 empties the cache when written-data bits 31:13 equal the cached page, and leaves it untouched otherwise.
- R10: Any write to register offset 0x00 or 0x08 empties the cache.
- R11: `req_ready` is 0 from the cycle after acceptance until the response is taken. `rsp_valid`, `rsp_paddr` and `rsp_fault` hold while `rsp_ready` is 0. A fetch request holds its address until it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register byte offset (0x00 control, 0x08 table base, 0x10 flush) |
| reg_wdata | input | 64 | Register write data |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Unit idle and able to accept a request |
| req_addr | input | 32 | Device address to translate |
| req_write | input | 1 | 1 for a write access, 0 for a read |
| mem_req_valid | output | 1 | Entry fetch request valid |
| mem_req_ready | input | 1 | Memory accepts the fetch |
| mem_req_addr | output | 34 | Physical address of the 8-byte entry |
| mem_rsp_valid | input | 1 | Entry data valid |
| mem_rsp_data | input | 64 | Fetched entry |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Requester takes the response |
| rsp_paddr | output | 34 | Translated physical address |
| rsp_attr | output | 4 | {streamable, local, cacheable, writable} |
| rsp_fault | output | 2 | 0 none, 1 out of range, 2 invalid, 3 protection |

## Verification
The bench probes the window edges for several size codes: the first and last byte of the window and the byte just below the base. If the base were computed one page off, a below-window address would start a fetch or an edge address would fault. It checks that invalid entries are refetched while protection-faulting ones are served from the cache. A design that cached the wrong entries would show an unexpected fetch count. Flushes that name another page, and register rewrites with unchanged values, separate a tag-compared flush from a blanket one. A stalled response that drifted, or a port that took a second request, would show up while `rsp_ready` is held low.

// File: rtl/dvma_pkg.sv
// Shared types and field positions for the device address translation unit.
// Assumes 64-bit table entries and byte register offsets.
package dvma_pkg;

    // Response fault codes, visible on rsp_fault
    typedef enum logic [1:0] {
        FLT_NONE    = 2'd0,
        FLT_RANGE   = 2'd1,
        FLT_INVALID = 2'd2,
        FLT_PROT    = 2'd3
    } fault_e;

    // Request sequencing states
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_WAIT  = 2'd2,
        ST_RESP  = 2'd3
    } state_e;

    // Register byte offsets
    localparam logic [4:0] OFF_CTRL  = 5'h00;
    localparam logic [4:0] OFF_BASE  = 5'h08;
    localparam logic [4:0] OFF_FLUSH = 5'h10;

    // Control word fields
    localparam int CTL_EN_BIT = 0;
    localparam int CTL_SZ_LSB = 16;

    // Table entry fields
    localparam int ENT_VALID_BIT = 63;
    localparam int ENT_STRM_BIT  = 60;
    localparam int ENT_LOCAL_BIT = 59;
    localparam int ENT_CACHE_BIT = 4;
    localparam int ENT_WRITE_BIT = 1;

endpackage

// File: rtl/dvma_cfg.sv
// Configuration registers: control enable, size code and table base.
// Also decodes the cache invalidation events caused by register writes.
// Assumes writes arrive only while the unit is idle.
module dvma_cfg
    import dvma_pkg::*;
#(
    parameter int VA_W     = 32,
    parameter int PA_W     = 34,
    parameter int PG_SHIFT = 13,
    parameter int SZ_W     = 3,
    parameter int REG_AW   = 5,
    parameter int DATA_W   = 64
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [REG_AW-1:0]       wr_addr,
    input  logic [DATA_W-1:0]       wr_data,
    output logic                    xl_en,
    output logic [SZ_W-1:0]         sz_code,
    output logic [PA_W-1:0]         tbl_base,
    output logic                    inv_all,
    output logic                    flush_en,
    output logic [VA_W-PG_SHIFT-1:0] flush_page
);
    localparam int BASE_HI_W = PA_W - PG_SHIFT;

    logic                 en_q;
    logic [SZ_W-1:0]      sz_q;
    logic [BASE_HI_W-1:0] base_hi_q;
    logic                 hit_ctrl, hit_base;
    logic                 unused_data;

    // Decode which register the current write targets
    always_comb begin
        hit_ctrl = wr_en && (wr_addr == REG_AW'(OFF_CTRL));
        hit_base = wr_en && (wr_addr == REG_AW'(OFF_BASE));
        flush_en = wr_en && (wr_addr == REG_AW'(OFF_FLUSH));
        inv_all  = hit_ctrl || hit_base;
    end

    // Hold the enable, size code and page-aligned table base
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q      <= 1'b0;
            sz_q      <= '0;
            base_hi_q <= '0;
        end else begin
            if (hit_ctrl) begin
                en_q <= wr_data[CTL_EN_BIT];
                sz_q <= wr_data[CTL_SZ_LSB +: SZ_W];
            end
            if (hit_base) base_hi_q <= wr_data[PG_SHIFT +: BASE_HI_W];
        end
    end

    assign xl_en       = en_q;
    assign sz_code     = sz_q;
    assign tbl_base    = {base_hi_q, {PG_SHIFT{1'b0}}};
    assign flush_page  = wr_data[PG_SHIFT +: (VA_W - PG_SHIFT)];
    assign unused_data = ^wr_data;

endmodule

// File: rtl/dvma_window.sv
// Window check and entry address generation, purely combinational.
// One window base per size code is built by a generate loop; the window
// always ends at the top of the device address space.
module dvma_window #(
    parameter int VA_W         = 32,
    parameter int PA_W         = 34,
    parameter int PG_SHIFT     = 13,
    parameter int SZ_W         = 3,
    parameter int MIN_WIN_LOG2 = 23,
    parameter int ENT_LOG2     = 3
) (
    input  logic [VA_W-1:0] va,
    input  logic [SZ_W-1:0] sz_code,
    input  logic [PA_W-1:0] tbl_base,
    output logic            in_win,
    output logic [PA_W-1:0] ent_addr
);
    localparam int NUM_SZ = 1 << SZ_W;
    localparam int SLOT_W = VA_W - PG_SHIFT;

    logic [VA_W-1:0]   win_base [NUM_SZ];
    logic [VA_W-1:0]   base_sel;
    logic [VA_W-1:0]   offset;
    logic [SLOT_W-1:0] slot;

    // Lowest mapped address for each size code
    for (genvar g = 0; g < NUM_SZ; g++) begin : g_base
        assign win_base[g] = ~((VA_W'(1) << (MIN_WIN_LOG2 + g)) - VA_W'(1));
    end

    // Range test and slot-to-entry address arithmetic
    always_comb begin
        base_sel = win_base[sz_code];
        in_win   = (va >= base_sel);
        offset   = va - base_sel;
        slot     = SLOT_W'(offset >> PG_SHIFT);
        ent_addr = tbl_base + (PA_W'(slot) << ENT_LOG2);
    end

endmodule

// File: rtl/dvma_tcache.sv
// Single-entry translation cache holding one page tag with its frame number
// and attributes. Invalidation has priority over a fill in the same cycle.
module dvma_tcache #(
    parameter int TAG_W  = 19,
    parameter int PPN_W  = 21,
    parameter int ATTR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TAG_W-1:0]  look_tag,
    output logic              hit,
    output logic [PPN_W-1:0]  hit_ppn,
    output logic [ATTR_W-1:0] hit_attr,
    input  logic              fill_en,
    input  logic [TAG_W-1:0]  fill_tag,
    input  logic [PPN_W-1:0]  fill_ppn,
    input  logic [ATTR_W-1:0] fill_attr,
    input  logic              inv_all,
    input  logic              flush_en,
    input  logic [TAG_W-1:0]  flush_tag
);
    logic              vld_q;
    logic [TAG_W-1:0]  tag_q;
    logic [PPN_W-1:0]  ppn_q;
    logic [ATTR_W-1:0] attr_q;

    // Keep, drop or replace the single cached translation
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q  <= 1'b0;
            tag_q  <= '0;
            ppn_q  <= '0;
            attr_q <= '0;
        end else if (inv_all || (flush_en && flush_tag == tag_q)) begin
            vld_q <= 1'b0;
        end else if (fill_en) begin
            vld_q  <= 1'b1;
            tag_q  <= fill_tag;
            ppn_q  <= fill_ppn;
            attr_q <= fill_attr;
        end
    end

    assign hit      = vld_q && (look_tag == tag_q);
    assign hit_ppn  = ppn_q;
    assign hit_attr = attr_q;

endmodule

// File: rtl/dvma_xlate.sv
// Device address translation unit, top level. Accepts one request at a
// time, answers from bypass, range check or cache in one cycle, otherwise
// fetches the table entry and answers when it returns.
// Assumes register writes occur only while req_ready is high.
module dvma_xlate
    import dvma_pkg::*;
#(
    parameter int VA_W         = 32,
    parameter int PA_W         = 34,
    parameter int PG_SHIFT     = 13,
    parameter int SZ_W         = 3,
    parameter int MIN_WIN_LOG2 = 23,
    parameter int REG_AW       = 5,
    parameter int ENT_W        = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [ENT_W-1:0]  reg_wdata,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [VA_W-1:0]   req_addr,
    input  logic              req_write,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [PA_W-1:0]   mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [ENT_W-1:0]  mem_rsp_data,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic [PA_W-1:0]   rsp_paddr,
    output logic [3:0]        rsp_attr,
    output logic [1:0]        rsp_fault
);
    localparam int TAG_W  = VA_W - PG_SHIFT;
    localparam int PPN_W  = PA_W - PG_SHIFT;
    localparam int ATTR_W = 4;

    state_e             st_q;
    logic [VA_W-1:0]    va_q;
    logic               wr_q;
    logic [PA_W-1:0]    fa_q;
    logic [PA_W-1:0]    pa_q;
    logic [ATTR_W-1:0]  at_q;
    fault_e             flt_q;

    logic               xl_en, inv_all, flush_en, in_win;
    logic [SZ_W-1:0]    sz_code;
    logic [PA_W-1:0]    tbl_base, ent_addr;
    logic [TAG_W-1:0]   flush_page;
    logic               c_hit;
    logic [PPN_W-1:0]   c_ppn;
    logic [ATTR_W-1:0]  c_attr;

    logic               e_valid;
    logic [PPN_W-1:0]   e_ppn;
    logic [ATTR_W-1:0]  e_attr;
    logic               fill_en;
    logic               unused_ent;

    dvma_cfg #(
        .VA_W(VA_W), .PA_W(PA_W), .PG_SHIFT(PG_SHIFT),
        .SZ_W(SZ_W), .REG_AW(REG_AW), .DATA_W(ENT_W)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n),
        .wr_en(reg_wr_en), .wr_addr(reg_addr), .wr_data(reg_wdata),
        .xl_en(xl_en), .sz_code(sz_code), .tbl_base(tbl_base),
        .inv_all(inv_all), .flush_en(flush_en), .flush_page(flush_page)
    );

    dvma_window #(
        .VA_W(VA_W), .PA_W(PA_W), .PG_SHIFT(PG_SHIFT),
        .SZ_W(SZ_W), .MIN_WIN_LOG2(MIN_WIN_LOG2), .ENT_LOG2(3)
    ) u_win (
        .va(req_addr), .sz_code(sz_code), .tbl_base(tbl_base),
        .in_win(in_win), .ent_addr(ent_addr)
    );

    dvma_tcache #(
        .TAG_W(TAG_W), .PPN_W(PPN_W), .ATTR_W(ATTR_W)
    ) u_cache (
        .clk(clk), .rst_n(rst_n),
        .look_tag(req_addr[VA_W-1:PG_SHIFT]),
        .hit(c_hit), .hit_ppn(c_ppn), .hit_attr(c_attr),
        .fill_en(fill_en), .fill_tag(va_q[VA_W-1:PG_SHIFT]),
        .fill_ppn(e_ppn), .fill_attr(e_attr),
        .inv_all(inv_all), .flush_en(flush_en), .flush_tag(flush_page)
    );

    // Split the fetched entry into the fields the unit uses
    always_comb begin
        e_valid = mem_rsp_data[ENT_VALID_BIT];
        e_ppn   = mem_rsp_data[PG_SHIFT +: PPN_W];
        e_attr  = {mem_rsp_data[ENT_STRM_BIT], mem_rsp_data[ENT_LOCAL_BIT],
                   mem_rsp_data[ENT_CACHE_BIT], mem_rsp_data[ENT_WRITE_BIT]};
        fill_en = (st_q == ST_WAIT) && mem_rsp_valid && e_valid;
    end
    assign unused_ent = ^mem_rsp_data;

    // Request sequencing and response registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            va_q  <= '0;
            wr_q  <= 1'b0;
            fa_q  <= '0;
            pa_q  <= '0;
            at_q  <= '0;
            flt_q <= FLT_NONE;
        end else begin
            case (st_q)
                ST_IDLE: if (req_valid) begin
                    va_q <= req_addr;
                    wr_q <= req_write;
                    fa_q <= ent_addr;
                    pa_q <= '0;
                    at_q <= '0;
                    flt_q <= FLT_NONE;
                    st_q <= ST_RESP;
                    if (!xl_en) begin
                        pa_q <= PA_W'(req_addr);
                    end else if (!in_win) begin
                        flt_q <= FLT_RANGE;
                    end else if (c_hit) begin
                        if (req_write && !c_attr[0]) begin
                            flt_q <= FLT_PROT;
                        end else begin
                            pa_q <= {c_ppn, req_addr[PG_SHIFT-1:0]};
                            at_q <= c_attr;
                        end
                    end else begin
                        st_q <= ST_FETCH;
                    end
                end
                ST_FETCH: if (mem_req_ready) st_q <= ST_WAIT;
                ST_WAIT: if (mem_rsp_valid) begin
                    st_q <= ST_RESP;
                    if (!e_valid) begin
                        flt_q <= FLT_INVALID;
                    end else if (wr_q && !e_attr[0]) begin
                        flt_q <= FLT_PROT;
                    end else begin
                        pa_q <= {e_ppn, va_q[PG_SHIFT-1:0]};
                        at_q <= e_attr;
                    end
                end
                default: if (rsp_ready) st_q <= ST_IDLE;
            endcase
        end
    end

    assign req_ready     = (st_q == ST_IDLE);
    assign mem_req_valid = (st_q == ST_FETCH);
    assign mem_req_addr  = fa_q;
    assign rsp_valid     = (st_q == ST_RESP);
    assign rsp_paddr     = pa_q;
    assign rsp_attr      = at_q;
    assign rsp_fault     = flt_q;

endmodule

// File: rtl/dvma_xlate_chk.sv
// Property checker for the translation unit, attached by bind.
module dvma_xlate_chk #(
    parameter int VA_W = 32,
    parameter int PA_W = 34
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic            req_ready,
    input logic [VA_W-1:0] req_addr,
    input logic            rsp_valid,
    input logic            rsp_ready,
    input logic [PA_W-1:0] rsp_paddr,
    input logic [1:0]      rsp_fault,
    input logic            mem_req_valid,
    input logic            mem_req_ready,
    input logic [PA_W-1:0] mem_req_addr,
    input logic            xl_en,
    input logic            in_win
);
    // R1
    reset_idle_chk: assert property (@(posedge clk)
        !rst_n |=> (req_ready && !rsp_valid && !mem_req_valid));

    // R11
    one_in_flight_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_ready && (rsp_valid || mem_req_valid)));

    // R11
    rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=>
            (rsp_valid && $stable(rsp_paddr) && $stable(rsp_fault)));

    // R11
    fetch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

    // R2
    bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !xl_en) |=>
            (rsp_valid && rsp_fault == 2'd0 && rsp_paddr == PA_W'($past(req_addr))));

    // R3
    range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && xl_en && !in_win) |=>
            (rsp_valid && rsp_fault == 2'd1 && !mem_req_valid));

endmodule

bind dvma_xlate dvma_xlate_chk #(.VA_W(VA_W), .PA_W(PA_W)) u_chk (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr),
    .xl_en(xl_en), .in_win(in_win)
);

// File: tb/dvma_xlate_tb.sv
`timescale 1ns/1ps
module dvma_xlate_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [63:0] reg_wdata = '0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_addr = '0;
    logic        req_write = 1'b0;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b1;
    logic [33:0] mem_req_addr;
    logic        mem_rsp_valid;
    logic [63:0] mem_rsp_data;
    logic        rsp_valid;
    logic        rsp_ready = 1'b1;
    logic [33:0] rsp_paddr;
    logic [3:0]  rsp_attr;
    logic [1:0]  rsp_fault;

    int          n_tests = 0;
    int          n_fail = 0;
    int          fetch_cnt = 0;
    logic [33:0] fetch_last = '0;
    logic [63:0] mem_entry = '0;

    always #10 clk = ~clk;

    dvma_xlate u_dut (
        .clk(clk), .rst_n(rst_n),
        .reg_wr_en(reg_wr_en), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_write(req_write),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
        .rsp_paddr(rsp_paddr), .rsp_attr(rsp_attr), .rsp_fault(rsp_fault)
    );

    // Memory model: one-cycle read latency, counts fetches
    always @(posedge clk) begin
        if (!rst_n) begin
            mem_rsp_valid <= 1'b0;
        end else begin
            mem_rsp_valid <= mem_req_valid && mem_req_ready;
            if (mem_req_valid && mem_req_ready) begin
                fetch_cnt  <= fetch_cnt + 1;
                fetch_last <= mem_req_addr;
            end
        end
    end
    assign mem_rsp_data = mem_entry;

    localparam logic [33:0] TBASE = 34'h2_4000_0000;

    typedef struct packed {
        logic [2:0]  sz;
        logic [31:0] addr;
        logic        wr;
        logic        v;
        logic        w;
        logic        c;
        logic        s;
        logic        l;
        logic [20:0] ppn;
        logic [1:0]  flt;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{3'd0, 32'hFF80_0000, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 21'h00123, 2'd0},
        '{3'd0, 32'hFFFF_FFFF, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 21'h1ABCD, 2'd0},
        '{3'd0, 32'hFF7F_FFFF, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 21'h00001, 2'd1},
        '{3'd7, 32'hC000_0000, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 21'h0F0F0, 2'd0},
        '{3'd7, 32'hBFFF_FFFF, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 21'h00002, 2'd1},
        '{3'd3, 32'hFC12_3456, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 21'h05555, 2'd2},
        '{3'd3, 32'hFD00_0010, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 21'h0AAAA, 2'd3},
        '{3'd3, 32'hFD00_0010, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 21'h0AAAA, 2'd0},
        '{3'd5, 32'hF000_0000, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 21'h1FFFF, 2'd0}
    };

    function automatic logic [63:0] mk_entry(input logic v, w, c, s, l,
                                             input logic [20:0] ppn);
        return {v, 2'b00, s, l, 25'd0, ppn, 8'd0, c, 2'b00, w, 1'b0};
    endfunction

    function automatic logic [31:0] win_lo(input logic [2:0] n);
        logic [32:0] span;
        span = 33'h80_0000 << n;
        return 32'(33'h1_0000_0000 - span);
    endfunction

    function automatic logic [33:0] exp_fetch(input logic [2:0] n, input logic [31:0] a);
        logic [31:0] pg;
        pg = (a - win_lo(n)) >> 13;
        return TBASE + 34'(pg) * 34'd8;
    endfunction

    function automatic logic [63:0] ctrl_word(input logic [2:0] n, input logic en,
                                              input logic [1:0] extra);
        return (64'(n) << 16) | (64'(extra) << 1) | 64'(en);
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic reg_write(input logic [4:0] a, input logic [63:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1;
        reg_addr  = a;
        reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic issue(input logic [31:0] a, input logic w,
                         output logic [33:0] pa, output logic [3:0] at,
                         output logic [1:0] f);
        @(negedge clk);
        req_valid = 1'b1;
        req_addr  = a;
        req_write = w;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        while (!rsp_valid) @(negedge clk);
        pa = rsp_paddr;
        at = rsp_attr;
        f  = rsp_fault;
        @(negedge clk);
    endtask

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (100000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog R11 actual=hung expected=finished");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [33:0] pa;
        logic [3:0]  at;
        logic [1:0]  f;
        int          f0;
        logic [21:0] p1, p2;

        repeat (4) @(negedge clk);
        chk("R1 req_ready in reset", 64'(req_ready), 64'd1);
        chk("R1 rsp_valid in reset", 64'(rsp_valid), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 mem_req_valid after reset", 64'(mem_req_valid), 64'd0);

        // R1 / R2: translation is off after reset
        f0 = fetch_cnt;
        issue(32'h1234_5678, 1'b0, pa, at, f);
        chk("R1 bypass paddr", 64'(pa), 64'h0_1234_5678);
        chk("R2 bypass fault", 64'(f), 64'd0);
        chk("R2 bypass attr", 64'(at), 64'd0);
        chk("R2 bypass no fetch", 64'(fetch_cnt - f0), 64'd0);
        issue(32'hFF80_0000, 1'b1, pa, at, f);
        chk("R2 bypass write paddr", 64'(pa), 64'h0_FF80_0000);

        // Vector table: R3..R7 across size codes
        reg_write(5'h08, 64'(TBASE) | 64'h1FFF);
        for (int i = 0; i < NV; i++) begin
            logic [33:0] e_pa;
            logic [3:0]  e_at;
            reg_write(5'h00, ctrl_word(VECS[i].sz, 1'b1, 2'(i)));
            mem_entry = mk_entry(VECS[i].v, VECS[i].w, VECS[i].c, VECS[i].s,
                                 VECS[i].l, VECS[i].ppn);
            f0 = fetch_cnt;
            issue(VECS[i].addr, VECS[i].wr, pa, at, f);
            e_pa = (VECS[i].flt == 2'd0) ? {VECS[i].ppn, VECS[i].addr[12:0]} : 34'd0;
            e_at = (VECS[i].flt == 2'd0) ? {VECS[i].s, VECS[i].l, VECS[i].c, VECS[i].w} : 4'd0;
            chk($sformatf("R3/R6/R7 vec%0d fault", i), 64'(f), 64'(VECS[i].flt));
            chk($sformatf("R5 vec%0d paddr", i), 64'(pa), 64'(e_pa));
            chk($sformatf("R5 vec%0d attr", i), 64'(at), 64'(e_at));
            if (VECS[i].flt == 2'd1) begin
                chk($sformatf("R3 vec%0d no fetch", i), 64'(fetch_cnt - f0), 64'd0);
            end else begin
                chk($sformatf("R4 vec%0d one fetch", i), 64'(fetch_cnt - f0), 64'd1);
                chk($sformatf("R4 vec%0d fetch addr", i), 64'(fetch_last),
                    64'(exp_fetch(VECS[i].sz, VECS[i].addr)));
            end
        end

        // R8: cache hit ignores a changed table
        reg_write(5'h00, ctrl_word(3'd0, 1'b1, 2'd0));
        p1 = 22'h0_1111;
        p2 = 22'h0_2222;
        mem_entry = mk_entry(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, p1[20:0]);
        f0 = fetch_cnt;
        issue(32'hFF80_2010, 1'b1, pa, at, f);
        chk("R4 fetch addr slot1", 64'(fetch_last), 64'(TBASE + 34'd8));
        mem_entry = mk_entry(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, p2[20:0]);
        issue(32'hFF80_3FFF, 1'b0, pa, at, f);
        chk("R8 hit no fetch", 64'(fetch_cnt - f0), 64'd1);
        chk("R8 hit paddr", 64'(pa), 64'({p1[20:0], 13'h1FFF}));

        // R9: flush of another page keeps, flush of cached page drops
        reg_write(5'h10, 64'hFF80_4000);
        issue(32'hFF80_2000, 1'b0, pa, at, f);
        chk("R9 other-page flush keeps", 64'(fetch_cnt - f0), 64'd1);
        chk("R9 kept paddr", 64'(pa), 64'({p1[20:0], 13'h0}));
        reg_write(5'h10, 64'hFF80_2ABC);
        issue(32'hFF80_2000, 1'b0, pa, at, f);
        chk("R9 same-page flush refetch", 64'(fetch_cnt - f0), 64'd2);
        chk("R9 new paddr", 64'(pa), 64'({p2[20:0], 13'h0}));

        // R10: rewriting base or control with same value drops the entry
        reg_write(5'h08, 64'(TBASE));
        issue(32'hFF80_2000, 1'b0, pa, at, f);
        chk("R10 base write refetch", 64'(fetch_cnt - f0), 64'd3);
        reg_write(5'h00, ctrl_word(3'd0, 1'b1, 2'd0));
        issue(32'hFF80_2000, 1'b0, pa, at, f);
        chk("R10 ctrl write refetch", 64'(fetch_cnt - f0), 64'd4);

        // R2: disable bypasses even with a cached page
        reg_write(5'h00, ctrl_word(3'd0, 1'b1, 2'd0));
        issue(32'hFF80_2000, 1'b0, pa, at, f);
        reg_write(5'h00, ctrl_word(3'd0, 1'b0, 2'd0));
        f0 = fetch_cnt;
        issue(32'hFF80_2000, 1'b0, pa, at, f);
        chk("R2 disabled paddr", 64'(pa), 64'h0_FF80_2000);
        chk("R2 disabled no fetch", 64'(fetch_cnt - f0), 64'd0);

        // R6: invalid entries are not cached
        reg_write(5'h00, ctrl_word(3'd0, 1'b1, 2'd0));
        mem_entry = mk_entry(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 21'h777);
        f0 = fetch_cnt;
        issue(32'hFF90_0000, 1'b0, pa, at, f);
        issue(32'hFF90_0004, 1'b0, pa, at, f);
        chk("R6 invalid refetched", 64'(fetch_cnt - f0), 64'd2);
        chk("R6 invalid fault", 64'(f), 64'd2);

        // R7: protection-faulting entry is cached
        mem_entry = mk_entry(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 21'h888);
        f0 = fetch_cnt;
        issue(32'hFFA0_0000, 1'b0, pa, at, f);
        chk("R7 read ok", 64'(f), 64'd0);
        issue(32'hFFA0_0100, 1'b1, pa, at, f);
        chk("R7 write fault from cache", 64'(f), 64'd3);
        chk("R7 fault paddr zero", 64'(pa), 64'd0);
        chk("R7 served from cache", 64'(fetch_cnt - f0), 64'd1);

        // R11: stalled response holds and blocks new requests
        rsp_ready = 1'b0;
        @(negedge clk);
        req_valid = 1'b1;
        req_addr  = 32'hFFA0_0200;
        req_write = 1'b0;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_addr = 32'h0000_0040;
        while (!rsp_valid) @(negedge clk);
        pa = rsp_paddr;
        repeat (3) @(negedge clk);
        chk("R11 rsp held", 64'(rsp_valid), 64'd1);
        chk("R11 req_ready low", 64'(req_ready), 64'd0);
        chk("R11 paddr stable", 64'(rsp_paddr), 64'(pa));
        chk("R11 stalled paddr", 64'(pa), 64'({21'h888, 13'h200}));
        req_valid = 1'b0;
        rsp_ready = 1'b1;
        @(negedge clk);
        chk("R11 released ready", 64'(req_ready), 64'd1);
        chk("R11 released rsp", 64'(rsp_valid), 64'd0);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule